// File: doc/BRIEF.md
# Non-volatile store sequencer with busy flag

This block runs the store cycle that copies a freshly received 8-bit channel value into a small persistent register array. The serial front end raises a single-cycle frame-complete strobe together with the decoded channel address and data. If the program request is already high on that clock edge, the sequencer accepts a store. It then holds a ready/busy output low for a programmable number of clock cycles, which stands in for the programming time of the storage cells. During that time it also raises a gate that tells the serial interface to ignore its data input and leave its data output undriven.

A supply-good input qualifies the store. If supply is low when the frame completes, the request is refused: ready/busy stays high and nothing is written. If supply falls while a store is running, the store is abandoned and ready/busy returns high. The array is written only on the last cycle of a completed store, and reset never clears it. The clock must keep running through the whole cycle, because every timing step is a clock count.

Top module: `nv_store_seq`

## Requirements
- R1: After reset, readyBusy is 1 and serialBlock is 0.
- R2: When frameDone, progReq and supplyOk are all 1 on a clock edge while readyBusy is 1, readyBusy is 0 from the next cycle for exactly PROG_CYCLES cycles, provided supplyOk stays 1.
- R3: serialBlock is 1 in exactly the cycles in which a store is running, meaning the cycles in which readyBusy is 0.
- R4: When a store completes, the channel given by frameAddr holds frameData at nvArray bits [ch*DATA_W +: DATA_W], visible in the same cycle that readyBusy returns to 1. No other channel changes, and the array never changes while readyBusy is 1.
- R5: A frameDone with progReq at 0 starts no store: readyBusy stays 1 and the array is unchanged.
- R6: A frameDone with progReq at 1 and supplyOk at 0 starts no store: readyBusy stays 1 and the array is unchanged.
- R7: If supplyOk is 0 on any edge while a store is running, the store is dropped: readyBusy is 1 from the next cycle and the array is unchanged.
- R8: A frameDone that arrives while a store is running is ignored. The running store keeps its length and its value, and the later address and data are not written.
- R9: Reset does not alter the array contents.
- R10: progReq has effect only on an edge where frameDone is 1. Holding progReq high without frameDone starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| progReq | input | 1 | Program request, sampled on the frameDone edge |
| frameDone | input | 1 | One-cycle strobe marking a received frame |
| frameAddr | input | ADDR_W | Channel address of the received frame |
| frameData | input | DATA_W | New channel value of the received frame |
| supplyOk | input | 1 | Supply high enough to program |
| readyBusy | output | 1 | 1 = ready, 0 = store in progress |
| serialBlock | output | 1 | Tells the serial interface to ignore input and release output |
| nvArray | output | NUM_CH*DATA_W | Persistent contents, channel ch at bits [ch*DATA_W +: DATA_W] |

## Verification
A wrong cycle count or a stuck state shows up on readyBusy within PROG_CYCLES+1 cycles of an accepted frame. The low phase is either the wrong length or never ends. A wrong staged address or data byte stays hidden until the store completes, and then shows as a wrong or misplaced byte on nvArray in the same cycle that readyBusy rises. A missing supply qualification shows one cycle after the refused or aborted edge, as readyBusy low or as a changed array.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture frame address and data
    logic commit;  // write staged value into the array
  } nvsStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} nvsState_t;
endpackage

// File: rtl/nvs_ctrl.sv
`timescale 1ns/1ps
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int PROG_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameDone,
  input  logic       progReq,
  input  logic       supplyOk,
  output nvsStrobe_t strobes,
  output logic       busy
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  nvsState_t        state;
  logic [CNT_W-1:0] cycLeft;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && frameDone && progReq && supplyOk;
    strobes.commit = (state == ST_BUSY) && (cycLeft == CNT_W'(1)) && supplyOk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cycLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobes.load) begin
            state   <= ST_BUSY;
            cycLeft <= CNT_W'(PROG_CYCLES);
          end
        end
        default: begin
          if (!supplyOk || cycLeft == CNT_W'(1)) begin
            state   <= ST_IDLE;
            cycLeft <= '0;
          end else begin
            cycLeft <= cycLeft - CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_BUSY);
endmodule

// File: rtl/nvs_datapath.sv
`timescale 1ns/1ps
module nvs_datapath
  import nvs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  nvsStrobe_t               strobes,
  input  logic [ADDR_W-1:0]        frameAddr,
  input  logic [DATA_W-1:0]        frameData,
  output logic [NUM_CH*DATA_W-1:0] nvArray
);
  logic [ADDR_W-1:0] stageAddr;
  logic [DATA_W-1:0] stageData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageAddr <= '0;
      stageData <= '0;
    end else if (strobes.load) begin
      stageAddr <= frameAddr;
      stageData <= frameData;
    end
  end

  // Persistent cells: deliberately outside reset
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
    logic [DATA_W-1:0] cellQ;
    always_ff @(posedge clk) begin
      if (strobes.commit && stageAddr == ADDR_W'(ch))
        cellQ <= stageData;
    end
    assign nvArray[ch*DATA_W +: DATA_W] = cellQ;
  end
endmodule

// File: rtl/nv_store_seq.sv
`timescale 1ns/1ps
module nv_store_seq
  import nvs_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 6,
  localparam int ADDR_W     = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     progReq,
  input  logic                     frameDone,
  input  logic [ADDR_W-1:0]        frameAddr,
  input  logic [DATA_W-1:0]        frameData,
  input  logic                     supplyOk,
  output logic                     readyBusy,
  output logic                     serialBlock,
  output logic [NUM_CH*DATA_W-1:0] nvArray
);
  nvsStrobe_t strobes;
  logic       busy;

  nvs_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameDone(frameDone), .progReq(progReq),
    .supplyOk(supplyOk), .strobes(strobes), .busy(busy)
  );

  nvs_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .frameAddr(frameAddr),
    .frameData(frameData), .nvArray(nvArray)
  );

  assign readyBusy   = ~busy;
  assign serialBlock = busy;
endmodule

// File: rtl/nvs_checker.sv
`timescale 1ns/1ps
module nvs_checker #(
  parameter int ARR_W       = 32,
  parameter int PROG_CYCLES = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frameDone,
  input logic             progReq,
  input logic             supplyOk,
  input logic             readyBusy,
  input logic             serialBlock,
  input logic [ARR_W-1:0] nvArray
);
  logic [15:0] lowLen;

  always_ff @(posedge clk) begin
    if (!rst_n)          lowLen <= '0;
    else if (readyBusy)  lowLen <= '0;
    else                 lowLen <= lowLen + 16'd1;
  end

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    readyBusy && frameDone && progReq && supplyOk |=> !readyBusy); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    readyBusy && !$past(readyBusy) && $past(supplyOk) |-> lowLen == 16'(PROG_CYCLES)); // R2

  AST_GATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serialBlock) |-> $past(frameDone && progReq && supplyOk)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    readyBusy |=> $stable(nvArray)); // R4

  AST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    readyBusy && frameDone && !progReq |=> readyBusy); // R5

  AST_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    readyBusy && !supplyOk |=> readyBusy); // R6

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !readyBusy && !supplyOk |=> readyBusy && $stable(nvArray)); // R7
endmodule

bind nv_store_seq nvs_checker #(.ARR_W(NUM_CH*DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frameDone(frameDone), .progReq(progReq),
  .supplyOk(supplyOk), .readyBusy(readyBusy), .serialBlock(serialBlock),
  .nvArray(nvArray)
);

// File: tb/nv_store_seq_bench.sv
`timescale 1ns/1ps
module nv_store_seq_bench;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 8;
  localparam int P      = 6;
  localparam int ADDR_W = $clog2(NUM_CH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic progReq = 1'b0, frameDone = 1'b0, supplyOk = 1'b1;
  logic [ADDR_W-1:0] frameAddr = '0;
  logic [DATA_W-1:0] frameData = '0;
  logic readyBusy, serialBlock;
  logic [NUM_CH*DATA_W-1:0] nvArray;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] expMem [NUM_CH];

  always #2.5 clk = ~clk;

  nv_store_seq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .PROG_CYCLES(P)) u_nv_store_seq (
    .clk(clk), .rst_n(rst_n), .progReq(progReq), .frameDone(frameDone),
    .frameAddr(frameAddr), .frameData(frameData), .supplyOk(supplyOk),
    .readyBusy(readyBusy), .serialBlock(serialBlock), .nvArray(nvArray)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkArray(input string req);
    for (int c = 0; c < NUM_CH; c++) begin
      int act = int'(nvArray[c*DATA_W +: DATA_W]);
      check(act == int'(expMem[c]), req, $sformatf("channel %0d", c), act, int'(expMem[c]));
    end
  endtask

  // Present one frame at a negedge; returns just after the next negedge
  task automatic sendFrame(input int ch, input int val, input bit req, input bit sup);
    frameDone = 1'b1; frameAddr = ADDR_W'(ch); frameData = DATA_W'(val);
    progReq = req; supplyOk = sup;
    @(negedge clk);
    frameDone = 1'b0; progReq = 1'b0;
  endtask

  // Count low cycles of readyBusy (first one already visible), checking the gate
  task automatic measureBusy(output int lowCnt);
    lowCnt = 0;
    while (!readyBusy && lowCnt < 4*P) begin
      lowCnt++;
      check(serialBlock == 1'b1, "R3", "serialBlock during store", int'(serialBlock), 1);
      @(negedge clk);
    end
    check(serialBlock == 1'b0, "R3", "serialBlock after store", int'(serialBlock), 0);
  endtask

  task automatic fullStore(input int ch, input int val);
    int n;
    sendFrame(ch, val, 1'b1, 1'b1);
    measureBusy(n);
    check(n == P, "R2", "busy length", n, P);
    expMem[ch] = DATA_W'(val);
    checkArray("R4");
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(readyBusy == 1'b1, "R1", "readyBusy after reset", int'(readyBusy), 1);
    check(serialBlock == 1'b0, "R1", "serialBlock after reset", int'(serialBlock), 0);

    // Establish known contents, then sweep every channel over every value
    for (int c = 0; c < NUM_CH; c++) fullStore(c, 0);
    for (int v = 0; v < 256; v++)
      for (int c = 0; c < NUM_CH; c++) fullStore(c, (v * 37 + c * 91) % 256);

    // R5: frame without program request
    sendFrame(1, 8'h5A, 1'b0, 1'b1);
    check(readyBusy == 1'b1, "R5", "readyBusy no request", int'(readyBusy), 1);
    repeat (P + 1) @(negedge clk);
    check(readyBusy == 1'b1, "R5", "readyBusy later", int'(readyBusy), 1);
    checkArray("R5");

    // R10: program request held without a frame strobe
    progReq = 1'b1;
    repeat (P + 2) begin
      @(negedge clk);
      check(readyBusy == 1'b1, "R10", "readyBusy req only", int'(readyBusy), 1);
    end
    progReq = 1'b0;
    checkArray("R10");

    // R6: low supply at acceptance
    sendFrame(2, 8'hC3, 1'b1, 1'b0);
    check(readyBusy == 1'b1, "R6", "readyBusy low supply", int'(readyBusy), 1);
    supplyOk = 1'b1;
    repeat (P + 1) @(negedge clk);
    check(readyBusy == 1'b1, "R6", "readyBusy later", int'(readyBusy), 1);
    checkArray("R6");

    // R7: supply drops in mid-store, at every possible busy cycle
    for (int k = 0; k < P; k++) begin
      sendFrame(3, 8'h0F ^ k, 1'b1, 1'b1);
      repeat (k) @(negedge clk);
      check(readyBusy == 1'b0, "R7", "still busy before drop", int'(readyBusy), 0);
      supplyOk = 1'b0;
      @(negedge clk);
      check(readyBusy == 1'b1, "R7", "readyBusy after drop", int'(readyBusy), 1);
      supplyOk = 1'b1;
      repeat (P + 1) @(negedge clk);
      check(readyBusy == 1'b1, "R7", "no restart", int'(readyBusy), 1);
      checkArray("R7");
    end

    // R8: a second frame during a store is ignored
    sendFrame(0, 8'hA5, 1'b1, 1'b1);
    check(readyBusy == 1'b0, "R8", "store started", int'(readyBusy), 0);
    @(negedge clk);
    sendFrame(1, 8'h3C, 1'b1, 1'b1);
    measureBusy(n);
    check(n == P - 2, "R8", "remaining busy length", n, P - 2);
    expMem[0] = 8'hA5;
    checkArray("R8");
    repeat (P + 1) @(negedge clk);
    check(readyBusy == 1'b1, "R8", "no second store", int'(readyBusy), 1);
    checkArray("R8");

    // R9: reset keeps the array
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(readyBusy == 1'b1, "R9", "readyBusy after re-reset", int'(readyBusy), 1);
    checkArray("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule